// File: doc/BRIEF.md
# Single-Error-Correcting GF(2^4) Multiplier with Predicted Check Bits

This block multiplies two elements of GF(2^4) whose field is built on the all-one polynomial x^4+x^3+x^2+x+1. It repairs any single bit that is wrong on the multiplier's output. Two paths run side by side. The first is the field multiplier. The second forms the unreduced 7-coefficient polynomial product of the same operands and derives three check bits from it. A third small stage computes three check bits from the multiplier's actual output and XORs the two sets into a syndrome. It then decodes that syndrome into a one-hot mask that flips the bad bit back.

A fault-injection mask is XORed onto the raw multiplier result before the checking stage. This lets a system or a bench model upsets on the result wires. The outputs are the corrected product and a flag that is set whenever the syndrome is nonzero. A parameter selects a registered output stage with one cycle of latency or a purely combinational output. A second parameter picks one of two multiplier structures.

Top module: `gf_sec_mul`

## Requirements
- R1: With a zero fault mask, `prod` equals op_a·op_b reduced modulo x^4+x^3+x^2+x+1 for all 256 operand pairs. Bit i of every operand and result is the coefficient of x^i.
- R2: With a zero fault mask, `err_flag` is 0 for all 256 operand pairs.
- R3: Output bit j belongs to check bit r when bit r of its column is set. The columns, written s2s1s0, are bit0=011, bit1=110, bit2=101 and bit3=111. When exactly one bit of `fault_mask` is set, `prod` equals the fault-free product and `err_flag` is 1.
- R4: For a multi-bit fault, the syndrome is the XOR of the columns of the flipped bits. When it equals a column, that output bit is flipped and `err_flag` is 1. For example, a mask of 0011 gives syndrome 101 and flips bit 2.
- R5: A syndrome of 001, 010 or 100 sets `err_flag` and leaves the faulted product unchanged. A multi-bit fault with syndrome 000, such as mask 0111, gives `err_flag` 0 and the faulted product.
- R6: With OUT_REG=1, `prod` and `err_flag` reflect the inputs sampled at the previous rising clock edge, and both are 0 while `rst_n` is low. With OUT_REG=0, they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | M | First operand, bit i is the x^i coefficient |
| op_b | input | M | Second operand |
| fault_mask | input | M | Bits XORed onto the raw multiplier result |
| prod | output | M | Corrected product |
| err_flag | output | 1 | Nonzero syndrome seen |

## Verification
The bench builds two instances with M=4 and the default check columns. The first is registered and uses the extended-basis multiplier. The second is combinational and uses the shift-and-reduce multiplier. Both instances see every operand pair under all sixteen fault masks. This covers clean operation, every single-bit repair, every miscorrecting double fault, the unmatched-syndrome cases and the zero-syndrome triple fault. The two instances therefore confirm that both multiplier structures agree with the predicted check bits, and that the registered variant holds exactly one cycle of latency.

// File: rtl/gfec_pkg.sv
package gfec_pkg;

   typedef enum logic [0:0] {
      MUL_EXTENDED = 1'b0,
      MUL_SHIFT    = 1'b1
   } mul_style_e;

   function automatic bit is_prime(input int n);
      if (n < 2) return 1'b0;
      for (int d = 2; d * d <= n; d++) begin
         if (n % d == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   // order of 2 modulo n must be n-1
   function automatic bit two_is_primitive(input int n);
      int v;
      v = 1;
      for (int e = 1; e < n; e++) begin
         v = (v * 2) % n;
         if (v == 1) return (e == n - 1);
      end
      return 1'b0;
   endfunction

   function automatic bit aop_irreducible(input int m);
      return is_prime(m + 1) && two_is_primitive(m + 1);
   endfunction

endpackage

// File: rtl/gf_aop_mul.sv
module gf_aop_mul #(
   parameter int                  M     = 4,
   parameter gfec_pkg::mul_style_e STYLE = gfec_pkg::MUL_EXTENDED
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] c
);

   localparam int N = M + 1;

   if (STYLE == gfec_pkg::MUL_EXTENDED) begin : g_ext
      // coefficients over the extended basis 1..x^M, using x^(M+1)=1
      logic [M:0] ext;
      always_comb begin
         ext = '0;
         for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
               ext[(i + j) % N] = ext[(i + j) % N] ^ (a[i] & b[j]);
            end
         end
      end
      always_comb begin
         for (int k = 0; k < M; k++) begin
            c[k] = ext[k] ^ ext[M];
         end
      end
   end else begin : g_shift
      // interleaved multiply, x^M folded to the sum of all lower powers
      always_comb begin
         logic [M-1:0] acc;
         logic [M-1:0] sh;
         logic         top;
         acc = '0;
         sh  = a;
         for (int i = 0; i < M; i++) begin
            if (b[i]) acc = acc ^ sh;
            top = sh[M-1];
            sh  = {sh[M-2:0], 1'b0} ^ {M{top}};
         end
         c = acc;
      end
   end

endmodule

// File: rtl/gf_parity_predict.sv
module gf_parity_predict #(
   parameter int           M          = 4,
   parameter int           R          = 3,
   parameter logic [M*R-1:0] CHECK_COLS = 12'b111_101_110_011
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [R-1:0] pred
);

   localparam int PW = 2 * M - 1;
   localparam int N  = M + 1;

   // row r selects the extended coefficients whose XOR equals check bit r
   function automatic logic [M:0] row_sel(input int r);
      logic [M:0] s;
      s = '0;
      for (int k = 0; k < M; k++) s[k] = CHECK_COLS[k*R + r];
      s[M] = ^s[M-1:0];
      return s;
   endfunction

   logic [PW-1:0] poly;
   logic [M:0]    folded;

   // plain polynomial product, no reduction
   always_comb begin
      poly = '0;
      for (int k = 0; k < PW; k++) begin
         for (int i = 0; i < M; i++) begin
            if (k - i >= 0 && k - i < M) poly[k] = poly[k] ^ (a[i] & b[k-i]);
         end
      end
   end

   // fold high terms with x^(M+1)=1
   always_comb begin
      for (int k = 0; k <= M; k++) begin
         folded[k] = poly[k];
         if (k + N < PW) folded[k] = folded[k] ^ poly[k + N];
      end
   end

   for (genvar r = 0; r < R; r++) begin : g_row
      localparam logic [M:0] SEL = row_sel(r);
      assign pred[r] = ^(folded & SEL);
   end

endmodule

// File: rtl/gf_syndrome_fix.sv
module gf_syndrome_fix #(
   parameter int             M          = 4,
   parameter int             R          = 3,
   parameter logic [M*R-1:0] CHECK_COLS = 12'b111_101_110_011
) (
   input  logic [M-1:0] data_in,
   input  logic [R-1:0] pred,
   output logic [M-1:0] data_out,
   output logic         bad
);

   function automatic logic [M-1:0] row_mask(input int r);
      logic [M-1:0] s;
      for (int k = 0; k < M; k++) s[k] = CHECK_COLS[k*R + r];
      return s;
   endfunction

   logic [R-1:0] seen;
   logic [R-1:0] syn;
   logic [M-1:0] flip;

   for (genvar r = 0; r < R; r++) begin : g_chk
      localparam logic [M-1:0] ROW = row_mask(r);
      assign seen[r] = ^(data_in & ROW);
   end

   assign syn = seen ^ pred;

   for (genvar j = 0; j < M; j++) begin : g_dec
      assign flip[j] = (syn == CHECK_COLS[j*R +: R]);
   end

   assign data_out = data_in ^ flip;
   assign bad      = |syn;

endmodule

// File: rtl/gf_sec_mul.sv
module gf_sec_mul #(
   parameter int                   M          = 4,
   parameter int                   R          = 3,
   parameter logic [M*R-1:0]       CHECK_COLS = 12'b111_101_110_011,
   parameter gfec_pkg::mul_style_e STYLE      = gfec_pkg::MUL_EXTENDED,
   parameter bit                   OUT_REG    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [M-1:0] op_a,
   input  logic [M-1:0] op_b,
   input  logic [M-1:0] fault_mask,
   output logic [M-1:0] prod,
   output logic         err_flag
);

   function automatic bit cols_valid();
      for (int j = 0; j < M; j++) begin
         if (CHECK_COLS[j*R +: R] == '0) return 1'b0;
         for (int k = j + 1; k < M; k++) begin
            if (CHECK_COLS[j*R +: R] == CHECK_COLS[k*R +: R]) return 1'b0;
         end
      end
      return 1'b1;
   endfunction

   if (!gfec_pkg::aop_irreducible(M)) begin : g_bad_field
      $error("gf_sec_mul: all-one polynomial of degree M is reducible");
   end
   if (M < 2 || R < 2) begin : g_bad_size
      $error("gf_sec_mul: M and R must be at least 2");
   end
   if (!cols_valid()) begin : g_bad_cols
      $error("gf_sec_mul: check columns must be nonzero and distinct");
   end

   logic [M-1:0] raw_c;
   logic [M-1:0] faulty_c;
   logic [M-1:0] corr_c;
   logic [R-1:0] pred_chk;
   logic         flag_c;

   gf_aop_mul #(.M(M), .STYLE(STYLE)) u_mul (
      .a (op_a),
      .b (op_b),
      .c (raw_c)
   );

   gf_parity_predict #(.M(M), .R(R), .CHECK_COLS(CHECK_COLS)) u_pred (
      .a    (op_a),
      .b    (op_b),
      .pred (pred_chk)
   );

   assign faulty_c = raw_c ^ fault_mask;

   gf_syndrome_fix #(.M(M), .R(R), .CHECK_COLS(CHECK_COLS)) u_fix (
      .data_in  (faulty_c),
      .pred     (pred_chk),
      .data_out (corr_c),
      .bad      (flag_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prod     <= '0;
            err_flag <= 1'b0;
         end else begin
            prod     <= corr_c;
            err_flag <= flag_c;
         end
      end
   end else begin : g_comb
      assign prod     = corr_c;
      assign err_flag = flag_c;
   end

endmodule

// File: rtl/gf_sec_mul_chk.sv
module gf_sec_mul_chk #(
   parameter int M       = 4,
   parameter bit OUT_REG = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [M-1:0] fault_mask,
   input logic [M-1:0] raw_c,
   input logic [M-1:0] faulty_c,
   input logic [M-1:0] corr_c,
   input logic         flag_c,
   input logic [M-1:0] prod,
   input logic         err_flag
);

   a_r1_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mask == '0) |-> (corr_c == raw_c));

   a_r2_clean_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_mask == '0) |-> !flag_c);

   a_r3_single_repair: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(fault_mask) |-> (flag_c && corr_c == raw_c));

   a_r4_pair_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(fault_mask) == 2) |-> flag_c);

   a_r5_at_most_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(corr_c ^ faulty_c) <= 1);

   a_r5_flip_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_c != faulty_c) |-> flag_c);

   if (OUT_REG) begin : g_lat
      a_r6_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (prod == $past(corr_c) && err_flag == $past(flag_c)));
   end else begin : g_now
      a_r6_comb_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (prod == corr_c && err_flag == flag_c));
   end

endmodule

bind gf_sec_mul gf_sec_mul_chk #(.M(M), .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fault_mask (fault_mask),
   .raw_c      (raw_c),
   .faulty_c   (faulty_c),
   .corr_c     (corr_c),
   .flag_c     (flag_c),
   .prod       (prod),
   .err_flag   (err_flag)
);

// File: tb/tb_gf_sec_mul.sv
module tb_gf_sec_mul;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_a = '0;
   logic [3:0] op_b = '0;
   logic [3:0] fault_mask = '0;
   logic [3:0] prod_r, prod_c;
   logic       flag_r, flag_c;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   gf_sec_mul #(.STYLE(gfec_pkg::MUL_EXTENDED), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .fault_mask(fault_mask), .prod(prod_r), .err_flag(flag_r));

   gf_sec_mul #(.STYLE(gfec_pkg::MUL_SHIFT), .OUT_REG(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .fault_mask(fault_mask), .prod(prod_c), .err_flag(flag_c));

   // reference: full product, then long division by x^4+x^3+x^2+x+1
   function automatic logic [3:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
      logic [6:0] p;
      p = '0;
      for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
      for (int d = 6; d >= 4; d--) if (p[d]) p = p ^ (7'h1F << (d - 4));
      return p[3:0];
   endfunction

   logic [3:0] exp_p_q[$];
   logic       exp_f_q[$];
   string      tag_q[$];

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic queue_expect(input logic [3:0] a, input logic [3:0] b, input logic [3:0] f);
      int         col[4] = '{3, 6, 5, 7};
      int         syn;
      logic [3:0] fix;
      logic [3:0] clean;
      string      tag;
      syn = 0;
      fix = '0;
      for (int j = 0; j < 4; j++) if (f[j]) syn = syn ^ col[j];
      for (int j = 0; j < 4; j++) if (col[j] == syn) fix[j] = 1'b1;
      clean = ref_mul(a, b);
      if (f == 4'h0)                 tag = "R1 R2 clean";
      else if ($countones(f) == 1)   tag = "R3 single fault";
      else if (fix != 4'h0)          tag = "R4 matched syndrome";
      else                           tag = "R5 unmatched or zero syndrome";
      exp_p_q.push_back(clean ^ f ^ fix);
      exp_f_q.push_back(syn != 0);
      tag_q.push_back(tag);
   endtask

   task automatic check_pending();
      logic [3:0] ep;
      logic       ef;
      string      tag;
      ep  = exp_p_q.pop_front();
      ef  = exp_f_q.pop_front();
      tag = tag_q.pop_front();
      check({"R6 registered prod, ", tag}, prod_r, ep);
      check({"R6 registered flag, ", tag}, {3'b0, flag_r}, {3'b0, ef});
      check({"comb prod, ", tag}, prod_c, ep);
      check({"comb flag, ", tag}, {3'b0, flag_c}, {3'b0, ef});
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R6: outputs held at zero during reset despite live operands
      op_a = 4'h7;
      op_b = 4'h9;
      fault_mask = 4'h2;
      repeat (3) @(negedge clk);
      check("R6 reset prod", prod_r, 4'h0);
      check("R6 reset flag", {3'b0, flag_r}, 4'h0);
      rst_n = 1'b1;
      fault_mask = 4'h0;
      op_a = 4'h0;
      op_b = 4'h0;
      for (int f = 0; f < 16; f++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               @(negedge clk);
               if (exp_p_q.size() != 0) check_pending();
               op_a       = 4'(a);
               op_b       = 4'(b);
               fault_mask = 4'(f);
               queue_expect(4'(a), 4'(b), 4'(f));
            end
         end
      end
      @(negedge clk);
      check_pending();
      finish_run();
   end

endmodule